// File: doc/BRIEF.md
# Edge-Coded Isolation Link Sender

This block is the sending half of a multi-line logic isolation link, sized by default for five lines. Each line's pin is brought into the clock domain through a two-flop synchronizer. The block compares the synchronized value with the level it last reported. Whenever the level changes, it puts a one-cycle message on that line's pair of strobes: `set_hi` for a new high level and `set_lo` for a new low level. The receiving side therefore only needs to set or clear a flop per line.

Between edges, a per-line background timer resends the line's current level. This repairs a far side that lost a message, or that came up later than the sender. Any edge or resume message on a line restarts that line's timer, so a refresh always falls one full interval after the latest message.

A side enable gates the input path in the way a gated latch would. While it is low, the reported level of every line is frozen and pin changes cause no edge messages. The refresh timers keep running and resend the frozen level. When the enable is sampled high after being low, or for the first time after reset, every line sends its current synchronized level at once.

Top module: `iso_edge_tx`

## Requirements
- R1: While reset is asserted, every `set_hi` and `set_lo` bit is 0.
- R2: A low-to-high change on `line_in[i]` while enabled raises `set_hi[i]` for exactly one cycle, on the third rising clock edge after the change. No other line's strobes are affected.
- R3: A high-to-low change on `line_in[i]` while enabled raises `set_lo[i]` for exactly one cycle, with the same timing as R2.
- R4: `set_hi[i]` and `set_lo[i]` are never 1 in the same cycle.
- R5: When a line has had no message for `REFRESH_CYCLES` clock edges, it sends its held level: `set_hi` if the level is 1, `set_lo` if it is 0. This happens whether or not the enable is high.
- R6: An edge or resume message on a line restarts only that line's refresh interval. Other lines keep their own schedule.
- R7: While `enable` is 0, pin changes produce no edge messages and the held level stays frozen. Refresh messages in this period carry the old level.
- R8: On the first clock edge that samples `enable` at 1 after it was 0, or after reset, every line sends its current synchronized level.
- R9: A high pulse on a line lasting a single clock cycle produces `set_hi` and then `set_lo` on that line, in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Input path enable; low freezes the held levels |
| line_in | input | LINES | Asynchronous line inputs |
| set_hi | output | LINES | One-cycle strobe: far side sets the line high |
| set_lo | output | LINES | One-cycle strobe: far side sets the line low |

## Verification
An input change is due on the strobes three rising edges later: two synchronizer stages plus the output register. An enable rise is due one edge later. A refresh is due exactly `REFRESH_CYCLES` edges after the line's previous message. The bench drives and samples on falling edges. Every quiet cycle inside each window is checked to be all-zero, so a message that arrives early or late is caught as well as a missing one. The bench uses a short refresh interval so that the timers of lines that were restarted at different times can be told apart.

// File: rtl/iso_edge_tx.sv
module iso_edge_tx #(
  parameter int LINES          = 5,
  parameter int REFRESH_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] set_hi,
  output logic [LINES-1:0] set_lo
);
  localparam int CW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

  logic [LINES-1:0] meta, syncd;
  logic             en_q;
  logic             resume;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta  <= '0;
      syncd <= '0;
      en_q  <= 1'b0;
    end else begin
      meta  <= line_in;
      syncd <= meta;
      en_q  <= enable;
    end
  end

  assign resume = enable & ~en_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [CW-1:0] cnt;
    logic          lvl, hi_r, lo_r;
    logic          evt, tick;

    assign evt  = resume | (enable & (syncd[i] ^ lvl));
    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        lvl  <= 1'b0;
        hi_r <= 1'b0;
        lo_r <= 1'b0;
      end else if (evt) begin
        cnt  <= '0;
        lvl  <= syncd[i];
        hi_r <= syncd[i];
        lo_r <= ~syncd[i];
      end else if (tick) begin
        cnt  <= '0;
        hi_r <= lvl;
        lo_r <= ~lvl;
      end else begin
        cnt  <= cnt + 1'b1;
        hi_r <= 1'b0;
        lo_r <= 1'b0;
      end
    end

    assign set_hi[i] = hi_r;
    assign set_lo[i] = lo_r;

    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_r && lo_r));
    a_r2_hi_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
      hi_r |-> lvl);
    a_r3_lo_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
      lo_r |-> !lvl);
    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(lvl));
    a_r8_resume_sends: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !en_q) |=> (hi_r || lo_r));
    a_r5_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
  end

endmodule

// File: tb/iso_edge_tx_test.sv
module iso_edge_tx_test;
  localparam int L = 5;
  localparam int R = 40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic [L-1:0] line_in;
  logic [L-1:0] set_hi, set_lo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  iso_edge_tx #(.LINES(L), .REFRESH_CYCLES(R)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line_in(line_in),
    .set_hi(set_hi), .set_lo(set_lo)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [L-1:0] eh, logic [L-1:0] el);
    checks++;
    if (set_hi !== eh || set_lo !== el) begin
      failures++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b at %0t",
               tag, set_hi, set_lo, eh, el, $time);
    end
  endtask

  task automatic quiet(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, '0, '0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; line_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", '0, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    @(negedge clk);
    chk("R8 first enable after reset", '0, 5'b11111);
  endtask

  task automatic t_refresh();
    quiet(R - 1, "R5 quiet before refresh");
    @(negedge clk);
    chk("R5 refresh of low level", '0, 5'b11111);
  endtask

  task automatic t_rise();
    line_in = 5'b00100;
    quiet(2, "R2 synchronizer latency");
    @(negedge clk);
    chk("R2 rising edge", 5'b00100, '0);
    @(negedge clk);
    chk("R4 single-cycle strobe", '0, '0);
  endtask

  task automatic t_fall();
    line_in = 5'b00000;
    quiet(2, "R3 synchronizer latency");
    @(negedge clk);
    chk("R3 falling edge", '0, 5'b00100);
  endtask

  task automatic t_restart();
    quiet(32, "R6 quiet");
    @(negedge clk);
    chk("R6 untouched lines refresh", '0, 5'b11011);
    quiet(6, "R6 quiet");
    @(negedge clk);
    chk("R6 restarted line refresh", '0, 5'b00100);
  endtask

  task automatic t_pulse();
    line_in = 5'b00001;
    @(negedge clk);
    line_in = 5'b00000;
    @(negedge clk);
    chk("R9 latency", '0, '0);
    @(negedge clk);
    chk("R9 pulse high", 5'b00001, '0);
    @(negedge clk);
    chk("R9 pulse low", '0, 5'b00001);
  endtask

  task automatic t_disable();
    enable = 1'b0;
    @(negedge clk);
    chk("R7 no message on disable", '0, '0);
    line_in = 5'b11111;
    quiet(27, "R7 pin change ignored");
    @(negedge clk);
    chk("R7 refresh keeps held level", '0, 5'b11010);
    quiet(6, "R7 quiet");
    @(negedge clk);
    chk("R7 refresh keeps held level", '0, 5'b00100);
  endtask

  task automatic t_resume();
    enable = 1'b1;
    @(negedge clk);
    chk("R8 resume sends current level", 5'b11111, '0);
    @(negedge clk);
    chk("R8 resume single cycle", '0, '0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_refresh();
    t_rise();
    t_fall();
    t_restart();
    t_pulse();
    t_disable();
    t_resume();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule